// File: doc/BRIEF.md
# Read Prefetch Boundary Controller

This block sits on the read path of a bus bridge and governs how many DWORDs it fetches ahead from the target for one queued read request. When a request arrives, the block takes in the command, the prefetchable-space flag, the programmed cache line size, the start address and the flow-through flag. From these it works out the stop point. That point can be a single DWORD, a 16-DWORD or cache-line alignment, the second cache line, the point where the queue fills, or a 4KB page edge. The block then paces the fetch one DWORD per handshake and ends it early on a target disconnect, a full queue or the initiator finishing.

On the initiator side the block offers the fetched DWORDs. It flags the final one with a disconnect once prefetching has ended. When the initiator completes while fetched data is still undelivered, it raises a one-cycle discard pulse and returns to idle with cleared counters.

Requests use a valid/ready handshake. `req_ready` is high only while idle. Both data streams follow valid/ready rules: a DWORD moves on a cycle where valid and ready are both high. `fetch_valid` drops while `q_full` is high. `dlv_valid` never rises for data that has not been fetched. Neither valid waits for its ready. Address and cache line size are in DWORDs. The address input carries the start address's offset within its 4KB page, which is all the stop point depends on.

Top module: `rd_prefetch_ctl`

## Requirements
- R1: Command codes 0 (configuration read) and 1 (I/O read), and unused codes 5 to 7, fetch exactly one DWORD whatever the cache line size, prefetchable flag or flow-through flag.
- R2: Command 2 (memory read) with the prefetchable flag low fetches exactly one DWORD.
- R3: Command 2 with the prefetchable flag high fetches up to the next aligned boundary. The span is 16 - (A mod 16) DWORDs for cache line size 0 or 16, and C - (A mod C) for cache line size C in {1,2,4,8}. A is the start address, and an aligned start fetches a full span.
- R4: Command 3 (memory read line) uses the same spans as R3 whatever the prefetchable flag.
- R5: Command 4 (memory read multiple) fetches 2C - (A mod C) DWORDs for C in {1,2,4,8}. With cache line size 0 or 16 it fetches until `q_full` rises. In every mode, `fetch_valid` is low while `q_full` is high, and a high `q_full` ends the prefetch.
- R6: A cache line size other than 0, 1, 2, 4, 8 or 16 behaves exactly like 0.
- R7: With the flow-through flag high, command 3, command 4 and prefetchable command 2 fetch 1024 - (A mod 1024) DWORDs, unless `init_done` ends the prefetch earlier.
- R8: `tgt_disc` high during the fetch ends the prefetch. A DWORD accepted in that same cycle still counts.
- R9: `dlv_valid` is high only while fetched DWORDs remain undelivered. `dlv_last` is high on exactly the final delivered DWORD once prefetching has ended on its own.
- R10: `init_done` with undelivered DWORDs gives a `discard` pulse of exactly one cycle, starting the cycle after, and `req_ready` returns high at the same time. With no undelivered DWORDs, no pulse is raised.
- R11: `pf_stop` is high in exactly the cycle in which the prefetch ends.
- R12: After reset, `req_ready` is high and `fetch_valid`, `dlv_valid`, `dlv_last`, `pf_stop` and `discard` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_cmd | input | 3 | Command code (0 cfg, 1 I/O, 2 mem read, 3 read line, 4 read multiple) |
| req_pref | input | 1 | Target address lies in prefetchable space |
| req_cls | input | 8 | Cache line size in DWORDs |
| req_addr | input | 10 | Start DWORD address, offset within its 4KB page |
| req_flow | input | 1 | Flow-through mode |
| fetch_valid | output | 1 | Request for one more DWORD from the target |
| fetch_ready | input | 1 | Target supplies the DWORD |
| tgt_disc | input | 1 | Target disconnect |
| q_full | input | 1 | Read data queue full |
| pf_stop | output | 1 | Prefetch ends this cycle |
| dlv_valid | output | 1 | A fetched DWORD awaits the initiator |
| dlv_ready | input | 1 | Initiator takes the DWORD |
| dlv_last | output | 1 | Disconnect accompanies this DWORD |
| init_done | input | 1 | Initiator ends the transaction |
| discard | output | 1 | Leftover data dropped (one cycle) |

## Verification
The bench targets off-by-one spans: unaligned and aligned starts, the second-line case, and a page start four DWORDs short of the edge. A design that counts the stop from zero instead of from the address offset would fetch a full span every time. A design that treats an aligned start as already on the boundary would fetch nothing. An illegal cache line size is sent to catch a decoder that maps it to a small line. A same-cycle disconnect checks that the DWORD in flight is kept rather than lost. The discard check ends the initiator mid-drain to catch a pulse that lingers or never fires, and it ends one request with nothing buffered to catch a spurious pulse. Each drain confirms that only the final DWORD carries the disconnect.

// File: rtl/rpf_pkg.sv
package rpf_pkg;
  typedef enum logic [2:0] {
    CMD_CFG = 3'd0,
    CMD_IO  = 3'd1,
    CMD_MR  = 3'd2,
    CMD_MRL = 3'd3,
    CMD_MRM = 3'd4
  } rd_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DRAIN
  } pf_state_e;

  typedef enum logic [2:0] {
    LIM_ONE,
    LIM_BLOCK,
    LIM_LINE,
    LIM_LINE2,
    LIM_QFULL,
    LIM_PAGE
  } lim_kind_e;
endpackage

// File: rtl/rpf_cls_decode.sv
module rpf_cls_decode #(
  parameter int CLS_W  = 8,
  parameter int BLK_DW = 16,
  localparam int BLK_LG = $clog2(BLK_DW)
) (
  input  logic [CLS_W-1:0]  cls,
  output logic              small_line,
  output logic [BLK_LG-1:0] line_sz,
  output logic [BLK_LG-1:0] line_mask
);
  logic [BLK_LG-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < BLK_LG; g++) begin : g_pow
      assign hit[g] = (cls == CLS_W'(1 << g));
    end
  endgenerate

  assign small_line = |hit;
  assign line_sz    = cls[BLK_LG-1:0];
  assign line_mask  = cls[BLK_LG-1:0] - BLK_LG'(1);
endmodule

// File: rtl/rpf_limit_calc.sv
module rpf_limit_calc
  import rpf_pkg::*;
#(
  parameter int CW      = 12,
  parameter int BLK_DW  = 16,
  parameter int PAGE_DW = 1024,
  localparam int BLK_LG = $clog2(BLK_DW),
  localparam int PG_LG  = $clog2(PAGE_DW)
) (
  input  logic [2:0]        cmd,
  input  logic              pref,
  input  logic              flow,
  input  logic [PG_LG-1:0]  addr,
  input  logic              small_line,
  input  logic [BLK_LG-1:0] line_sz,
  input  logic [BLK_LG-1:0] line_mask,
  output logic [CW-1:0]     limit
);
  lim_kind_e kind;
  logic      pf_cmd;
  logic [CW-1:0] blk_off, line_off, page_off, line_dw;

  assign blk_off  = CW'(addr[BLK_LG-1:0]);
  assign line_off = CW'(addr[BLK_LG-1:0] & line_mask);
  assign page_off = CW'(addr);
  assign line_dw  = CW'(line_sz);
  assign pf_cmd   = (cmd == CMD_MR && pref) || cmd == CMD_MRL || cmd == CMD_MRM;

  always_comb begin
    kind = LIM_ONE;
    if (flow && pf_cmd) begin
      kind = LIM_PAGE;
    end else begin
      case (cmd)
        CMD_MR:  if (pref) kind = small_line ? LIM_LINE : LIM_BLOCK;
        CMD_MRL: kind = small_line ? LIM_LINE : LIM_BLOCK;
        CMD_MRM: kind = small_line ? LIM_LINE2 : LIM_QFULL;
        default: kind = LIM_ONE;
      endcase
    end
  end

  always_comb begin
    case (kind)
      LIM_BLOCK: limit = CW'(BLK_DW) - blk_off;
      LIM_LINE:  limit = line_dw - line_off;
      LIM_LINE2: limit = (line_dw << 1) - line_off;
      LIM_QFULL: limit = '1;
      LIM_PAGE:  limit = CW'(PAGE_DW) - page_off;
      default:   limit = CW'(1);
    endcase
  end
endmodule

// File: rtl/rd_prefetch_ctl.sv
module rd_prefetch_ctl
  import rpf_pkg::*;
#(
  parameter int CW      = 12,
  parameter int CLS_W   = 8,
  parameter int BLK_DW  = 16,
  parameter int PAGE_DW = 1024
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [2:0]                 req_cmd,
  input  logic                       req_pref,
  input  logic [CLS_W-1:0]           req_cls,
  input  logic [$clog2(PAGE_DW)-1:0] req_addr,
  input  logic                       req_flow,
  output logic                       fetch_valid,
  input  logic                       fetch_ready,
  input  logic                       tgt_disc,
  input  logic                       q_full,
  output logic                       pf_stop,
  output logic                       dlv_valid,
  input  logic                       dlv_ready,
  output logic                       dlv_last,
  input  logic                       init_done,
  output logic                       discard
);
  localparam int BLK_LG = $clog2(BLK_DW);

  pf_state_e         state_q;
  logic [CW-1:0]     fcnt_q, dcnt_q, lim_q, limit_w, fcnt_n, dcnt_n;
  logic              small_line, fire_f, fire_d, end_fetch, leftover;
  logic              discard_q;
  logic [BLK_LG-1:0] line_sz, line_mask;

  rpf_cls_decode #(.CLS_W(CLS_W), .BLK_DW(BLK_DW)) u_cls (
    .cls(req_cls), .small_line(small_line), .line_sz(line_sz), .line_mask(line_mask)
  );

  rpf_limit_calc #(.CW(CW), .BLK_DW(BLK_DW), .PAGE_DW(PAGE_DW)) u_lim (
    .cmd(req_cmd), .pref(req_pref), .flow(req_flow), .addr(req_addr),
    .small_line(small_line), .line_sz(line_sz), .line_mask(line_mask), .limit(limit_w)
  );

  assign req_ready   = (state_q == ST_IDLE);
  assign fetch_valid = (state_q == ST_FETCH) && !q_full;
  assign fire_f      = fetch_valid && fetch_ready;
  assign fcnt_n      = fcnt_q + CW'(fire_f);
  assign dlv_valid   = (state_q != ST_IDLE) && (dcnt_q < fcnt_q);
  assign fire_d      = dlv_valid && dlv_ready;
  assign dcnt_n      = dcnt_q + CW'(fire_d);
  assign dlv_last    = dlv_valid && (state_q == ST_DRAIN) && (dcnt_q + CW'(1) == fcnt_q);
  assign end_fetch   = (fcnt_n == lim_q) || tgt_disc || q_full;
  assign pf_stop     = (state_q == ST_FETCH) && (end_fetch || init_done);
  assign leftover    = (fcnt_n != dcnt_n);
  assign discard     = discard_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      fcnt_q    <= '0;
      dcnt_q    <= '0;
      lim_q     <= CW'(1);
      discard_q <= 1'b0;
    end else begin
      discard_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          fcnt_q <= '0;
          dcnt_q <= '0;
          if (req_valid) begin
            lim_q   <= limit_w;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (init_done || (end_fetch && !leftover)) begin
            discard_q <= init_done && leftover;
            state_q   <= ST_IDLE;
            fcnt_q    <= '0;
            dcnt_q    <= '0;
          end else begin
            fcnt_q <= fcnt_n;
            dcnt_q <= dcnt_n;
            if (end_fetch) state_q <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (init_done || (fire_d && dlv_last)) begin
            discard_q <= init_done && leftover;
            state_q   <= ST_IDLE;
            fcnt_q    <= '0;
            dcnt_q    <= '0;
          end else begin
            dcnt_q <= dcnt_n;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rd_prefetch_ctl_chk.sv
module rd_prefetch_ctl_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          fetch_valid,
  input logic          q_full,
  input logic          tgt_disc,
  input logic          dlv_valid,
  input logic          dlv_last,
  input logic          discard,
  input logic [CW-1:0] fcnt,
  input logic [CW-1:0] dcnt,
  input logic [CW-1:0] lim
);
  AST_FULL_BLOCKS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !fetch_valid); // R5
  AST_DISC_HALTS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && tgt_disc) |=> !fetch_valid); // R8
  AST_FETCH_WITHIN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (fcnt <= lim)); // R3
  AST_NO_OVERDRAW: assert property (@(posedge clk) disable iff (!rst_n)
    (dcnt <= fcnt)); // R9
  AST_LAST_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_last |-> dlv_valid); // R9
  AST_DISCARD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    discard |=> !discard); // R10
  AST_DISCARD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    discard |-> req_ready); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!fetch_valid && !dlv_valid)); // R12
endmodule

bind rd_prefetch_ctl rd_prefetch_ctl_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .fetch_valid(fetch_valid),
  .q_full(q_full), .tgt_disc(tgt_disc), .dlv_valid(dlv_valid), .dlv_last(dlv_last),
  .discard(discard), .fcnt(fcnt_q), .dcnt(dcnt_q), .lim(lim_q)
);

// File: tb/rd_prefetch_ctl_test.sv
module rd_prefetch_ctl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_pref = 0, req_flow = 0;
  logic [2:0] req_cmd = '0;
  logic [7:0] req_cls = '0;
  logic [9:0] req_addr = '0;
  logic fetch_ready = 0, tgt_disc = 0, q_full = 0, dlv_ready = 0, init_done = 0;
  logic req_ready, fetch_valid, pf_stop, dlv_valid, dlv_last, discard;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  rd_prefetch_ctl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_pref(req_pref), .req_cls(req_cls), .req_addr(req_addr),
    .req_flow(req_flow), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .tgt_disc(tgt_disc), .q_full(q_full), .pf_stop(pf_stop), .dlv_valid(dlv_valid),
    .dlv_ready(dlv_ready), .dlv_last(dlv_last), .init_done(init_done), .discard(discard)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start_req(input logic [2:0] c, input logic p, input logic [7:0] cl,
                           input logic [9:0] a, input logic f);
    @(negedge clk);
    req_valid = 1; req_cmd = c; req_pref = p; req_cls = cl; req_addr = a; req_flow = f;
    @(negedge clk);
    req_valid = 0;
  endtask

  // Counts fetched DWORDs until pf_stop; disc_at/qf_at give the total at which to stop
  task automatic run_fetch(output int n, input int disc_at, input int qf_at);
    bit stop;
    n = 0;
    fetch_ready = 1;
    for (int i = 0; i < 5000; i++) begin
      tgt_disc = (disc_at > 0 && n == disc_at - 1);
      q_full   = (qf_at >= 0 && n >= qf_at);
      #1;
      if (fetch_valid && fetch_ready) n++;
      stop = pf_stop;
      @(negedge clk);
      if (stop) break;
    end
    fetch_ready = 0; tgt_disc = 0; q_full = 0;
  endtask

  // Delivers everything, checks count and that only the final one carries dlv_last (R9)
  task automatic drain(input string req, input int exp);
    int cnt = 0;
    int bad = 0;
    dlv_ready = 1;
    for (int i = 0; i < 5000; i++) begin
      #1;
      if (req_ready && !dlv_valid) break;
      if (dlv_valid) begin
        cnt++;
        if (dlv_last != (cnt == exp)) bad++;
      end
      @(negedge clk);
    end
    dlv_ready = 0;
    check(cnt == exp, {req, " R9 delivered count"}, cnt, exp);
    check(bad == 0, {req, " R9 last flag placement"}, bad, 0);
  endtask

  task automatic span_case(input string req, input logic [2:0] c, input logic p,
                           input logic [7:0] cl, input logic [9:0] a, input logic f,
                           input int exp);
    int n;
    start_req(c, p, cl, a, f);
    run_fetch(n, 0, -1);
    check(n == exp, {req, " span"}, n, exp);
    drain(req, exp);
  endtask

  task automatic t_reset;
    #1;
    check(req_ready && !fetch_valid && !dlv_valid && !dlv_last && !pf_stop && !discard,
          "R12 reset outputs", {req_ready, fetch_valid, dlv_valid, dlv_last, pf_stop, discard},
          6'b100000);
  endtask

  task automatic t_disc;
    int n;
    start_req(3, 0, 0, 0, 0);
    run_fetch(n, 3, -1);
    check(n == 3, "R8 disconnect same-cycle DWORD kept", n, 3);
    drain("R8", 3);
  endtask

  task automatic t_qfull;
    int n;
    start_req(4, 1, 0, 7, 0);
    run_fetch(n, 0, 20);
    check(n == 20, "R5 queue-full stop", n, 20);
    drain("R5", 20);
  endtask

  task automatic t_discard;
    int n;
    start_req(3, 0, 16, 0, 0);
    run_fetch(n, 0, -1);
    check(n == 16, "R4 aligned full span", n, 16);
    dlv_ready = 1;
    @(negedge clk); @(negedge clk);
    dlv_ready = 0; init_done = 1;
    @(negedge clk);
    init_done = 0; #1;
    check(discard == 1, "R10 discard pulse", discard, 1);
    check(req_ready == 1, "R10 idle with discard", req_ready, 1);
    @(negedge clk); #1;
    check(discard == 0, "R10 discard one cycle", discard, 0);
  endtask

  task automatic t_flow_early;
    int n = 0;
    bit stop = 0;
    start_req(2, 1, 0, 0, 1);
    fetch_ready = 1;
    for (int i = 0; i < 5; i++) begin
      #1; if (fetch_valid) n++;
      @(negedge clk);
    end
    fetch_ready = 0; init_done = 1; #1;
    stop = pf_stop;
    @(negedge clk);
    init_done = 0; #1;
    check(n == 5, "R7 flow-through fetched before end", n, 5);
    check(stop == 1, "R11 pf_stop on initiator end", stop, 1);
    check(discard == 1, "R7 initiator end discards leftover", discard, 1);
    @(negedge clk);
  endtask

  task automatic t_nothing_left;
    start_req(3, 0, 0, 0, 0);
    init_done = 1;
    @(negedge clk);
    init_done = 0; #1;
    check(discard == 0, "R10 no discard without leftover", discard, 0);
    check(req_ready == 1, "R10 idle after end", req_ready, 1);
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog (R1..): actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    t_reset();
    @(negedge clk); rst_n = 1;
    span_case("R1 cfg", 0, 1, 8, 3, 0, 1);
    span_case("R1 io flow ignored", 1, 1, 0, 0, 1, 1);
    span_case("R1 unused code", 6, 1, 4, 2, 0, 1);
    span_case("R2 mr nonpref", 2, 0, 16, 5, 0, 1);
    span_case("R3 mr pref cls0", 2, 1, 0, 5, 0, 11);
    span_case("R3 mr pref cls4", 2, 1, 4, 6, 0, 2);
    span_case("R4 mrl cls8", 3, 0, 8, 3, 0, 5);
    span_case("R5 mrm cls4", 4, 0, 4, 1, 0, 7);
    span_case("R6 cls3 as 0", 3, 1, 3, 0, 0, 16);
    span_case("R7 flow page edge", 2, 1, 0, 10'd1020, 1, 4);
    span_case("R7 flow full page", 4, 0, 2, 0, 1, 1024);
    t_disc();
    t_qfull();
    t_discard();
    t_flow_early();
    t_nothing_left();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule